// File: doc/BRIEF.md
# Programmable 50%-Duty Integer Clock Divider

This block is one clock-output slice. It takes a single source clock and produces one derived clock at an integer fraction of the source frequency. A 3-bit divide code picks a ratio of 1 to 8: the ratio is the code plus one. A code of zero bypasses the counter and sends the source clock straight to the output. Even ratios come from a counter that toggles the output every ratio/2 source cycles. Odd ratios combine a rising-edge phase with a copy of it retimed on the falling edge, so that the high time is exactly half of the output period when the source has a 50% duty cycle.

A small word-wide register port, clocked by the source clock, sets the divide code, a power-down bit and an idle-polarity bit. A read-only status word reflects all three. A write of a new code never shortens or stretches the output period that is in progress: the new ratio is loaded at the next period boundary. Power-down works the same way. At the boundary the output is frozen at the idle level selected by the polarity bit, and it resumes cleanly at a later boundary once power-down is cleared.

Top module: `clkdiv_slice`

## Requirements
- R1: For divide codes 1 to 7 the `clk_out` period is (code+1) periods of `clk_in`.
- R2: With code 0, `clk_out` equals `clk_in`. Code 0 is the reset value, so `clk_out` follows `clk_in` right after reset.
- R3: With a 50%-duty `clk_in`, the high time of `clk_out` is half its period for all eight codes.
- R4: The configuration word at address 0 returns the divide code in bits 4..2. Bits 23..5 and 1..0 always read 0, whatever was written to them. The code resets to 0.
- R5: Bits 31..24 of the configuration word (source select) reset to 00h. A write that carries a nonzero value in this field leaves it unchanged, while the divide-code part of the same write is still taken.
- R6: The control word at address 2 holds power-down in bit 0 and idle polarity in bit 1. The read-only status word at address 1 returns the divide code in bits 4..2, polarity in bit 1 and power-down in bit 0. Writes to address 1 are ignored. Read data is registered and appears one `clk_in` cycle after `reg_addr`.
- R7: A new divide code takes effect only at the end of the output period in progress. That period and its high phase keep the old length.
- R8: While power-down is set, `clk_out` stops at the next period boundary, after the current high phase has finished. It then holds 0 if polarity is 0 and 1 if polarity is 1. Clearing power-down restores the programmed ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Source clock; also clocks the register port |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge of `clk_in` |
| reg_addr | input | 2 | Word address: 0 configuration, 1 status, 2 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's `reg_addr` |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
A register write lands on the rising edge of `clk_in` at which it is presented. Read data shows up one rising edge after the address, so the bench sets the address at a falling edge and samples at the next falling edge. A new ratio or a power-down request only shows up at `clk_out` at the next output-period boundary. For that reason the bench lets at least twenty source cycles pass after each write before it measures period and high time from `clk_out` edge timestamps. The exception is the retiming test, which measures on purpose the period that is already running when the write lands (old length expected) and the one after it (new length expected). The gated level is sampled only after the stop boundary is certain to have passed.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  // Register word map
  localparam int WORD_W   = 32;
  localparam int SEL_LSB  = 24;
  localparam int SEL_W    = 8;
  localparam int CODE_LSB = 2;
  localparam int POL_BIT  = 1;
  localparam int PDN_BIT  = 0;

  typedef enum logic [1:0] {
    A_CFG  = 2'd0,
    A_STAT = 2'd1,
    A_CTRL = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [CODE_W-1:0] code_q,
  output logic              pdn_q,
  output logic              pol_q
);
  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] rd_nxt;
  logic [SEL_W-1:0]  sel_in;

  assign sel_in = wdata[SEL_LSB +: SEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      code_q <= '0;
      pdn_q  <= 1'b0;
      pol_q  <= 1'b0;
    end else if (wr) begin
      case (reg_addr_e'(addr))
        A_CFG: begin
          code_q <= wdata[CODE_LSB +: CODE_W];
          // only the single legal source (zero) is accepted
          if (sel_in == '0) sel_q <= sel_in;
        end
        A_CTRL: begin
          pdn_q <= wdata[PDN_BIT];
          pol_q <= wdata[POL_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (reg_addr_e'(addr))
      A_CFG: begin
        rd_nxt[SEL_LSB +: SEL_W]   = sel_q;
        rd_nxt[CODE_LSB +: CODE_W] = code_q;
      end
      A_STAT: begin
        rd_nxt[CODE_LSB +: CODE_W] = code_q;
        rd_nxt[POL_BIT]            = pol_q;
        rd_nxt[PDN_BIT]            = pdn_q;
      end
      A_CTRL: begin
        rd_nxt[POL_BIT] = pol_q;
        rd_nxt[PDN_BIT] = pdn_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] pend_code,
  output logic [CODE_W-1:0] act_code,
  output logic [CODE_W-1:0] cnt_q,
  output logic              q_rise,
  output logic              odd_sel,
  output logic              bypass,
  output logic              wrap
);
  logic [CODE_W-1:0] cnt_nxt;
  logic [CODE_W-1:0] code_nxt;
  logic [CODE_W-1:0] hi_len;

  always_comb begin
    wrap     = (cnt_q == act_code);
    code_nxt = wrap ? pend_code : act_code;
    cnt_nxt  = wrap ? '0 : cnt_q + CODE_W'(1);
    // odd code -> even ratio: ratio/2 cycles high
    // even code -> odd ratio: (ratio-1)/2 cycles, the falling-edge copy adds half
    if (code_nxt[0]) hi_len = (code_nxt >> 1) + CODE_W'(1);
    else             hi_len = code_nxt >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_code <= '0;
      cnt_q    <= '0;
      q_rise   <= 1'b1;
    end else begin
      act_code <= code_nxt;
      cnt_q    <= cnt_nxt;
      q_rise   <= (code_nxt == '0) || (cnt_nxt < hi_len);
    end
  end

  assign bypass  = (act_code == '0);
  assign odd_sel = !bypass && !act_code[0];
endmodule

// File: rtl/clkdiv_gate.sv
`timescale 1ns/1ps
module clkdiv_gate (
  input  logic clk,
  input  logic rst,
  input  logic q_rise,
  input  logic odd_sel,
  input  logic bypass,
  input  logic wrap,
  input  logic pdn,
  input  logic pol,
  output logic stop_q,
  output logic clk_out
);
  logic q_fall;

  // half-cycle delayed copy of the rising-edge phase
  always_ff @(negedge clk) begin
    if (rst) q_fall <= 1'b0;
    else     q_fall <= q_rise;
  end

  // gating only changes at an output period boundary
  always_ff @(posedge clk) begin
    if (rst)       stop_q <= 1'b0;
    else if (wrap) stop_q <= pdn;
  end

  always_comb begin
    if (stop_q)       clk_out = pol;
    else if (bypass)  clk_out = clk;
    else if (odd_sel) clk_out = q_rise | q_fall;
    else              clk_out = q_rise;
  end
endmodule

// File: rtl/clkdiv_slice.sv
`timescale 1ns/1ps
module clkdiv_slice
  import clkdiv_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk_in,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              clk_out
);
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] act_code;
  logic [CODE_W-1:0] cnt_q;
  logic              pdn_q, pol_q;
  logic              q_rise, odd_sel, bypass, wrap, stop_q;

  clkdiv_regs #(.CODE_W(CODE_W)) u_regs (
    .clk    (clk_in),
    .rst    (rst),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .code_q (code_q),
    .pdn_q  (pdn_q),
    .pol_q  (pol_q)
  );

  clkdiv_core #(.CODE_W(CODE_W)) u_core (
    .clk       (clk_in),
    .rst       (rst),
    .pend_code (code_q),
    .act_code  (act_code),
    .cnt_q     (cnt_q),
    .q_rise    (q_rise),
    .odd_sel   (odd_sel),
    .bypass    (bypass),
    .wrap      (wrap)
  );

  clkdiv_gate u_gate (
    .clk     (clk_in),
    .rst     (rst),
    .q_rise  (q_rise),
    .odd_sel (odd_sel),
    .bypass  (bypass),
    .wrap    (wrap),
    .pdn     (pdn_q),
    .pol     (pol_q),
    .stop_q  (stop_q),
    .clk_out (clk_out)
  );
endmodule

// File: rtl/clkdiv_slice_chk.sv
`timescale 1ns/1ps
module clkdiv_slice_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              clk_out,
  input logic [CODE_W-1:0] code_q,
  input logic              pdn_q,
  input logic              pol_q,
  input logic [CODE_W-1:0] act_code,
  input logic [CODE_W-1:0] cnt_q,
  input logic              stop_q
);
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= act_code); // R1

  AST_CODE_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != act_code) |=> $stable(act_code)); // R7

  AST_SEL_ALWAYS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd0) |=> (reg_rdata[31:24] == 8'h00)); // R5

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[23:5] == '0); // R4

  AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd1) |=> (reg_rdata[4:0] == {$past(code_q), $past(pol_q), $past(pdn_q)})); // R6

  AST_STOP_LEVEL: assert property (@(posedge clk) disable iff (rst)
    stop_q |-> (clk_out == pol_q)); // R8
endmodule

bind clkdiv_slice clkdiv_slice_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk_in),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .clk_out   (clk_out),
  .code_q    (code_q),
  .pdn_q     (pdn_q),
  .pol_q     (pol_q),
  .act_code  (act_code),
  .cnt_q     (cnt_q),
  .stop_q    (stop_q)
);

// File: tb/clkdiv_slice_test.sv
`timescale 1ns/1ps
module clkdiv_slice_test;
  localparam realtime TCLK = 5.0;

  logic        clk_in = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        clk_out;

  int n_chk = 0;
  int n_err = 0;

  always #(TCLK/2) clk_in = ~clk_in;

  clkdiv_slice uut (
    .clk_in    (clk_in),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .clk_out   (clk_out)
  );

  task automatic chk32(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chkt(input string req, input realtime got, input realtime exp);
    n_chk++;
    if (got - exp > 0.01 || exp - got > 0.01) begin
      n_err++;
      $display("FAIL %s: got %0.3f ns expected %0.3f ns", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_in);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk_in);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_in);
    reg_addr = a;
    @(negedge clk_in);
    d = reg_rdata;
  endtask

  task automatic meas(output realtime hi, output realtime per);
    realtime t0, t1, t2;
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    hi  = t1 - t0;
    per = t2 - t0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(200000 * TCLK);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    realtime hi, per;
    realtime t0, t1, t2, t3, t4;
    int bad;

    repeat (4) @(negedge clk_in);
    rst = 1'b0;

    // reset state
    rd(2'd0, d); chk32("R4 reset cfg", d, 32'h0);
    rd(2'd1, d); chk32("R6 reset status", d, 32'h0);
    rd(2'd2, d); chk32("R6 reset ctrl", d, 32'h0);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk_in); #1;
      if (clk_out !== 1'b1) bad++;
      @(negedge clk_in); #1;
      if (clk_out !== 1'b0) bad++;
    end
    chk32("R2 bypass follows clk_in after reset", bad, 0);

    // sweep all divide codes
    for (int c = 0; c < 8; c++) begin
      wr(2'd0, 32'(c) << 2);
      repeat (20) @(negedge clk_in);
      meas(hi, per);
      if (c == 0) chkt("R2 bypass period", per, TCLK);
      else        chkt("R1 period", per, TCLK * (c + 1));
      chkt("R3 high time", hi, TCLK * (c + 1) / 2.0);
      rd(2'd1, d); chk32("R6 status code", d, 32'(c) << 2);
    end

    // reserved bits and source select
    wr(2'd0, 32'h00FF_FFFF);
    rd(2'd0, d); chk32("R4 reserved bits read 0", d, 32'h0000_001C);
    wr(2'd0, 32'hAB00_000C);
    rd(2'd0, d); chk32("R5 nonzero select rejected", d, 32'h0000_000C);
    wr(2'd0, 32'hFF00_0010);
    rd(2'd0, d); chk32("R5 select stays 00h", d, 32'h0000_0010);

    // status is read-only
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk32("R6 status write ignored", d, 32'h0000_0010);
    rd(2'd2, d); chk32("R6 ctrl unchanged by status write", d, 32'h0);

    // retiming: 8 -> 3 switched mid high phase
    wr(2'd0, 32'd7 << 2);
    repeat (20) @(negedge clk_in);
    @(posedge clk_out); t0 = $realtime;
    wr(2'd0, 32'd2 << 2);
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    @(negedge clk_out); t3 = $realtime;
    @(posedge clk_out); t4 = $realtime;
    chkt("R7 running high phase keeps old length", t1 - t0, 4 * TCLK);
    chkt("R7 running low phase keeps old length", t2 - t1, 4 * TCLK);
    chkt("R7 next high uses new ratio", t3 - t2, 1.5 * TCLK);
    chkt("R7 next low uses new ratio", t4 - t3, 1.5 * TCLK);

    // power-down, idle low then idle high
    wr(2'd0, 32'd3 << 2);
    repeat (20) @(negedge clk_in);
    wr(2'd2, 32'h1);
    repeat (20) @(negedge clk_in);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(posedge clk_in); #1;
      if (clk_out !== 1'b0) bad++;
      @(negedge clk_in); #1;
      if (clk_out !== 1'b0) bad++;
    end
    chk32("R8 stopped output holds 0", bad, 0);
    rd(2'd1, d); chk32("R6 status shows power-down", d, 32'h0000_000D);
    wr(2'd2, 32'h3);
    repeat (4) @(negedge clk_in);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(posedge clk_in); #1;
      if (clk_out !== 1'b1) bad++;
      @(negedge clk_in); #1;
      if (clk_out !== 1'b1) bad++;
    end
    chk32("R8 stopped output holds 1", bad, 0);
    rd(2'd1, d); chk32("R6 status shows polarity", d, 32'h0000_000F);
    rd(2'd2, d); chk32("R6 ctrl readback", d, 32'h0000_0003);
    wr(2'd2, 32'h0);
    repeat (20) @(negedge clk_in);
    meas(hi, per);
    chkt("R8 resumed period", per, 4 * TCLK);
    chkt("R8 resumed high time", hi, 2 * TCLK);

    finish_run();
  end
endmodule